// File: doc/BRIEF.md
# Sync Point Counter Wait Unit

This block holds a bank of event counters, each 24 bits wide, that engines use to order their work. It also holds a small set of base registers. A command stream drives the block. A command can bump a counter at once, or it can queue a bump that takes effect only when a named engine reports completion. Other commands load or advance a base register, or make the stream wait until a counter has reached a threshold.

The threshold of a wait is either absolute or a base register plus a 16-bit offset. Thresholds are compared in modular fashion, so a counter that wraps past zero still satisfies waits issued before the wrap. While a wait is unmet the block raises `stall` and refuses further commands. Engines pulse one-hot `eng_done` strobes. Each pulse retires the oldest queued bump for that engine.

Commands are a 3-bit kind plus a 32-bit payload. The kind codes are 0 = bump, 1 = wait, 2 = base load, 3 = base add and 4 = base-relative wait. Kinds 5 to 7 are accepted but have no effect. A read port shows any counter combinationally.

Top module: `syncpt_wait_unit`

## Requirements
- R1: After reset every counter and base reads zero, `stall` is low and `cmd_ready` is high.
- R2: A bump (kind 0) with condition byte `cmd_data[7:0]` = 0 adds one to counter `cmd_data[31:24]`. The new value shows on `rd_value` the cycle after acceptance.
- R3: A bump with condition c in 1..NUM_ENG is queued for engine c-1 and leaves the counter unchanged. Each `eng_done[c-1]` pulse retires the oldest queued bump, and that counter shows +1 the next cycle. A pulse with an empty queue does nothing.
- R4: When engine c-1 already holds QDEPTH queued bumps, `cmd_ready` is low for a bump with condition c. Retiring entries frees space again.
- R5: A wait (kind 1) carries the counter index in bits 31:24 and the threshold in bits 23:0. If the wait is met when it is accepted, `stall` stays low. Otherwise `stall` is high from the next cycle until the compare passes, and `cmd_ready` is low in every stalled cycle.
- R6: A wait is met when (counter − threshold) mod 2^24 has bit 23 clear. This holds across wraparound.
- R7: A base load (kind 2) writes `cmd_data[23:0]` into base `cmd_data[27:24]`. A base add (kind 3) adds `cmd_data[23:0]` to that base, modulo 2^24.
- R8: A base-relative wait (kind 4) waits on counter `cmd_data[31:24]`. Its threshold is base `cmd_data[19:16]` plus the zero-extended offset `cmd_data[15:0]`, modulo 2^24.
- R9: Counter indices use only their low log2(NUM_CNT) bits. Kinds 5–7 and bump conditions above NUM_ENG are accepted and change nothing.
- R10: Bumps that land on one counter in the same cycle, from a command and from several engines, all count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_kind | input | 3 | Command kind |
| cmd_data | input | 32 | Command payload |
| stall | output | 1 | A wait is pending and unmet |
| eng_done | input | NUM_ENG | Engine completion pulses |
| rd_idx | input | log2(NUM_CNT) | Counter selected for readback |
| rd_value | output | 24 | Value of the selected counter |

## Verification
The assertions assume that counters move by far less than 2^23 during a wait. Under that assumption an unmet wait can only clear after an engine retires a queued bump, and a met wait cannot fall back to unmet. The random stimulus keeps to this. It picks each wait threshold no higher than the counter's value plus the bumps already queued for it, so every stall is released by later done pulses. Base-relative waits are issued only when the needed offset fits in 16 bits; otherwise the bench sends a plain wait instead.

// File: rtl/syncpt_wait_unit.sv
module syncpt_wait_unit #(
  parameter int NUM_CNT  = 32,
  parameter int NUM_BASE = 16,
  parameter int NUM_ENG  = 4,
  parameter int QDEPTH   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [2:0]                 cmd_kind,
  input  logic [31:0]                cmd_data,
  output logic                       stall,
  input  logic [NUM_ENG-1:0]         eng_done,
  input  logic [$clog2(NUM_CNT)-1:0] rd_idx,
  output logic [23:0]                rd_value
);
  localparam int VAL_W  = 24;
  localparam int IDX_W  = $clog2(NUM_CNT);
  localparam int BIDX_W = $clog2(NUM_BASE);
  localparam int QP_W   = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int QC_W   = $clog2(QDEPTH + 1);
  localparam logic [2:0] K_BUMP = 3'd0, K_WAIT = 3'd1, K_LDB = 3'd2,
                         K_ADDB = 3'd3, K_WAITB = 3'd4;

  function automatic logic reached(input logic [VAL_W-1:0] c, input logic [VAL_W-1:0] t);
    logic [VAL_W-1:0] d;
    d = c - t;
    return ~d[VAL_W-1];
  endfunction

  logic [NUM_CNT-1:0][VAL_W-1:0]  cnt_q, cnt_d;
  logic [NUM_BASE-1:0][VAL_W-1:0] base_q;
  logic                           waiting;
  logic [IDX_W-1:0]               w_idx;
  logic [VAL_W-1:0]               w_thr;
  logic [NUM_ENG-1:0][IDX_W-1:0]  q_head;
  logic [NUM_ENG-1:0]             q_full, q_some, push, pop;
  logic                           blocked, fire;

  wire [IDX_W-1:0]  c_idx  = cmd_data[24 +: IDX_W];
  wire [BIDX_W-1:0] b_idx  = cmd_data[24 +: BIDX_W];
  wire [BIDX_W-1:0] wb_idx = cmd_data[16 +: BIDX_W];
  wire [7:0]        cond   = cmd_data[7:0];
  wire              is_bump = cmd_kind == K_BUMP;
  wire              is_wait = (cmd_kind == K_WAIT) || (cmd_kind == K_WAITB);
  wire [VAL_W-1:0]  thr_cmd = (cmd_kind == K_WAITB)
                              ? base_q[wb_idx] + VAL_W'(cmd_data[15:0])
                              : cmd_data[VAL_W-1:0];

  assign stall     = waiting && !reached(cnt_q[w_idx], w_thr);
  assign cmd_ready = !stall && !blocked;
  assign fire      = cmd_valid && cmd_ready;
  assign rd_value  = cnt_q[rd_idx];

  always_comb begin
    blocked = 1'b0;
    for (int e = 0; e < NUM_ENG; e++)
      if (is_bump && cond == 8'(e + 1) && q_full[e]) blocked = 1'b1;
  end

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
    logic [IDX_W-1:0] mem [QDEPTH];
    logic [QP_W-1:0]  rd_p, wr_p;
    logic [QC_W-1:0]  used;

    assign push[e]   = fire && is_bump && cond == 8'(e + 1);
    assign pop[e]    = eng_done[e] && used != '0;
    assign q_full[e] = used == QC_W'(QDEPTH);
    assign q_some[e] = used != '0;
    assign q_head[e] = mem[rd_p];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_p <= '0;
        wr_p <= '0;
        used <= '0;
      end else begin
        if (push[e]) begin
          mem[wr_p] <= c_idx;
          wr_p <= (wr_p == QP_W'(QDEPTH - 1)) ? '0 : wr_p + 1'b1;
        end
        if (pop[e]) rd_p <= (rd_p == QP_W'(QDEPTH - 1)) ? '0 : rd_p + 1'b1;
        used <= used + QC_W'(push[e]) - QC_W'(pop[e]);
      end
    end

    // R4
    q_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_full[e] |=> !(q_full[e] && $past(push[e])));
  end

  always_comb begin
    cnt_d = cnt_q;
    for (int e = 0; e < NUM_ENG; e++)
      if (pop[e]) cnt_d[q_head[e]] = cnt_d[q_head[e]] + VAL_W'(1);
    if (fire && is_bump && cond == 8'd0) cnt_d[c_idx] = cnt_d[c_idx] + VAL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      base_q  <= '0;
      waiting <= 1'b0;
      w_idx   <= '0;
      w_thr   <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (fire && cmd_kind == K_LDB)  base_q[b_idx] <= cmd_data[VAL_W-1:0];
      if (fire && cmd_kind == K_ADDB) base_q[b_idx] <= base_q[b_idx] + cmd_data[VAL_W-1:0];
      if (waiting && !stall) waiting <= 1'b0;
      if (fire && is_wait && !reached(cnt_q[c_idx], thr_cmd)) begin
        waiting <= 1'b1;
        w_idx   <= c_idx;
        w_thr   <= thr_cmd;
      end
    end
  end

  // R5
  stall_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(cmd_valid && cmd_ready && is_wait));
  // R5
  stall_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !(|(eng_done & q_some))) |=> stall);
  // R10
  idle_counters_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmd_valid && cmd_ready) && eng_done == '0) |=> $stable(cnt_q));
  // R7
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready && (cmd_kind == K_LDB || cmd_kind == K_ADDB)) |=> $stable(base_q));
endmodule

// File: tb/test_syncpt_wait_unit.sv
module test_syncpt_wait_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_kind = '0;
  logic [31:0] cmd_data = '0;
  logic        stall;
  logic [3:0]  eng_done = '0;
  logic [4:0]  rd_idx = '0;
  logic [23:0] rd_value;

  syncpt_wait_unit i_syncpt_wait_unit (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [23:0] m_cnt [32];
  logic [23:0] m_base [16];
  logic [4:0]  m_q [4][4];
  int          m_qh [4], m_qc [4];
  bit          m_wait;
  int          m_widx;
  logic [23:0] m_wthr;

  function automatic bit met(input logic [23:0] c, input logic [23:0] t);
    logic [23:0] d;
    d = c - t;
    return !d[23];
  endfunction

  function automatic int pending(input int idx);
    int n = 0;
    for (int e = 0; e < 4; e++)
      for (int j = 0; j < m_qc[e]; j++)
        if (m_q[e][(m_qh[e] + j) % 4] == 5'(idx)) n++;
    return n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input logic [2:0] k, input logic [31:0] d,
                     input logic [3:0] dn, input int ri, input string tag);
    bit es, blk, er, fire;
    int cnd, idx;
    logic [23:0] pre [32];
    logic [23:0] thr;
    cmd_valid = v; cmd_kind = k; cmd_data = d; eng_done = dn; rd_idx = 5'(ri);
    #2;
    cnd = int'(d[7:0]);
    idx = int'(d[28:24]);
    es  = m_wait && !met(m_cnt[m_widx], m_wthr);
    blk = (k == 3'd0) && cnd >= 1 && cnd <= 4 && m_qc[cnd-1] == 4;
    er  = !es && !blk;
    chk("R5", 32'(stall), 32'(es));
    chk(blk ? "R4" : "R5", 32'(cmd_ready), 32'(er));
    chk(tag == "" ? "R2" : tag, 32'(rd_value), 32'(m_cnt[ri % 32]));
    fire = v && er;
    @(posedge clk);
    for (int i = 0; i < 32; i++) pre[i] = m_cnt[i];
    for (int e = 0; e < 4; e++)
      if (dn[e] && m_qc[e] > 0) begin
        m_cnt[m_q[e][m_qh[e]]]++;
        m_qh[e] = (m_qh[e] + 1) % 4;
        m_qc[e]--;
      end
    if (fire && k == 3'd0 && cnd == 0) m_cnt[idx]++;
    if (fire && k == 3'd0 && cnd >= 1 && cnd <= 4) begin
      m_q[cnd-1][(m_qh[cnd-1] + m_qc[cnd-1]) % 4] = 5'(idx);
      m_qc[cnd-1]++;
    end
    if (m_wait && met(pre[m_widx], m_wthr)) m_wait = 0;
    if (fire && (k == 3'd1 || k == 3'd4)) begin
      thr = (k == 3'd4) ? m_base[d[19:16]] + {8'd0, d[15:0]} : d[23:0];
      if (!met(pre[idx], thr)) begin
        m_wait = 1; m_widx = idx; m_wthr = thr;
      end
    end
    if (fire && k == 3'd2) m_base[d[27:24]] = d[23:0];
    if (fire && k == 3'd3) m_base[d[27:24]] = m_base[d[27:24]] + d[23:0];
    @(negedge clk);
  endtask

  function automatic logic [31:0] bump(input int idx, input int c);
    return {8'(idx), 16'd0, 8'(c)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R5 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    for (int i = 0; i < 32; i++) m_cnt[i] = '0;
    for (int i = 0; i < 16; i++) m_base[i] = '0;
    for (int e = 0; e < 4; e++) begin m_qh[e] = 0; m_qc[e] = 0; end
    m_wait = 0; m_widx = 0; m_wthr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cyc(0, 3'd0, '0, 4'h0, 0, "R1");
    cyc(0, 3'd0, '0, 4'h0, 31, "R1");
    // R2 immediate bump
    cyc(1, 3'd0, bump(3, 0), 4'h0, 3, "R2");
    cyc(0, 3'd0, '0, 4'h0, 3, "R2");
    // R9 index modulo, null kind, out-of-range condition
    cyc(1, 3'd0, bump(35, 0), 4'h0, 3, "R9");
    cyc(1, 3'd5, 32'hFFFF_FFFF, 4'h0, 3, "R9");
    cyc(1, 3'd0, bump(3, 9), 4'h0, 3, "R9");
    cyc(1, 3'd7, bump(3, 0), 4'h0, 3, "R9");
    cyc(0, 3'd0, '0, 4'h0, 3, "R9");
    // R3 queued bumps released by done pulses
    for (int j = 0; j < 3; j++) cyc(1, 3'd0, bump(2, 1), 4'h0, 2, "R3");
    cyc(0, 3'd0, '0, 4'h4, 2, "R3");
    cyc(1, 3'd1, {8'd2, 24'd3}, 4'h0, 2, "R3");
    for (int j = 0; j < 3; j++) cyc(1, 3'd0, bump(2, 0), 4'h1, 2, "R3");
    cyc(0, 3'd0, '0, 4'h0, 2, "R3");
    // R4 queue full back-pressure
    for (int j = 0; j < 4; j++) cyc(1, 3'd0, bump(7, 2), 4'h0, 7, "R4");
    cyc(1, 3'd0, bump(7, 2), 4'h0, 7, "R4");
    for (int j = 0; j < 4; j++) cyc(0, 3'd0, '0, 4'h2, 7, "R4");
    cyc(0, 3'd0, '0, 4'h0, 7, "R4");
    // R10 coincident bumps
    cyc(1, 3'd0, bump(4, 1), 4'h0, 4, "R10");
    cyc(1, 3'd0, bump(4, 2), 4'h0, 4, "R10");
    cyc(1, 3'd0, bump(4, 0), 4'h3, 4, "R10");
    cyc(0, 3'd0, '0, 4'h0, 4, "R10");
    // R7 R8 base load, base add, base-relative wait
    cyc(1, 3'd2, {8'd5, 24'd2}, 4'h0, 7, "R7");
    cyc(1, 3'd3, {8'd5, 24'd1}, 4'h0, 7, "R7");
    cyc(1, 3'd4, {8'd7, 8'd5, 16'd1}, 4'h0, 7, "R8");
    cyc(0, 3'd0, '0, 4'h0, 7, "R8");
    cyc(1, 3'd0, bump(7, 3), 4'h0, 7, "R8");
    cyc(1, 3'd4, {8'd7, 8'd5, 16'd2}, 4'h0, 7, "R8");
    cyc(0, 3'd0, '0, 4'h0, 7, "R8");
    cyc(0, 3'd0, '0, 4'h4, 7, "R8");
    cyc(0, 3'd0, '0, 4'h0, 7, "R8");
    // R6 wraparound compare
    cyc(1, 3'd1, {8'd3, 24'hFFFFF0}, 4'h0, 3, "R6");
    cyc(0, 3'd0, '0, 4'h0, 3, "R6");
    cyc(1, 3'd1, {8'd3, 24'h800003}, 4'h0, 3, "R6");
    cyc(0, 3'd0, '0, 4'h0, 3, "R6");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int sel, idx, b, want;
      logic [23:0] off;
      logic [3:0] dn;
      sel = int'($urandom % 8);
      idx = int'($urandom % 8);
      if ($urandom % 16 == 0) idx += 32;
      b = int'($urandom % 4);
      dn = 4'($urandom);
      want = int'(m_cnt[idx % 32]) + pending(idx % 32) - int'($urandom % 4);
      case (sel)
        0, 1: cyc(1, 3'd0, bump(idx, ($urandom % 2) ? 0 : int'($urandom % 6)), dn, int'($urandom % 8), "");
        2: cyc(1, 3'd1, {8'(idx), 24'(want)}, dn, idx % 32, "R6");
        3: cyc(1, 3'd2, {8'(b), 24'($urandom % 40)}, dn, int'($urandom % 8), "");
        4: cyc(1, 3'd3, {8'(b), 24'($urandom % 4)}, dn, int'($urandom % 8), "");
        5: begin
          off = 24'(want) - m_base[b];
          if (off[23:16] == 8'd0) cyc(1, 3'd4, {8'(idx), 8'(b), off[15:0]}, dn, idx % 32, "R8");
          else cyc(1, 3'd1, {8'(idx), 24'(want)}, dn, idx % 32, "R6");
        end
        6: cyc(1, 3'(5 + $urandom % 3), 32'($urandom), dn, int'($urandom % 8), "R9");
        default: cyc(0, 3'd0, '0, dn, int'($urandom % 8), "");
      endcase
    end
    for (int n = 0; n < 20; n++) cyc(0, 3'd0, '0, 4'hF, n, "R3");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule